// File: doc/BRIEF.md
# Cartridge Real-Time Clock Counter

This block keeps calendar-free wall time for a battery-backed cartridge. It holds seconds, minutes, hours and a nine-bit day count, plus a halt control and a sticky flag for day overflow. A prescaler turns a stream of elapsed time units into one-second ticks, and each tick moves the cascaded counters forward unless the clock is halted.

The time source reports on each clock cycle how many counting units have passed (`unit_step`, zero or more). Units add up in the prescaler, and when the total reaches `TICKS_PER_SEC` a tick fires and the excess stays for the next second. Software reads any field through a registered read port and writes any field through a single-cycle write port. The control byte packs the ninth day bit, the halt bit and the overflow flag.

Top module: `cart_rtc`

## Requirements
- R1: After reset every counter is 0, halt is 0 and overflow is 0. Read selects are: 0 seconds, 1 minutes, 2 hours, 3 day bits 7..0, 4 control; any other select reads 0xFF. The control byte is bit 7 overflow, bit 6 halt, bits 5..1 always read 1, bit 0 day bit 8, so after reset it reads 0x3E.
- R2: `rd_data` shows the field chosen by `rd_sel` one clock after `rd_sel` is presented.
- R3: Units from `unit_step` add up. When the sum reaches `TICKS_PER_SEC` one tick occurs and the amount above `TICKS_PER_SEC` is kept toward the next tick.
- R4: On a tick, seconds advance. Reaching 60 gives 0 and a carry into minutes. Minutes reaching 60 give 0 and a carry into hours. Hours reaching 24 give 0 and a carry into days.
- R5: The day count is nine bits. A carry with day bits 7..0 at 0xFF sets them to 0x00 and toggles day bit 8.
- R6: A day carry from 511 back to 0 sets the overflow flag. It stays set through later ticks until a write to the control byte with bit 7 = 0.
- R7: While halt is 1, no field advances and the prescaler does not accumulate units. Accumulation resumes from the held value when halt returns to 0.
- R8: A write to the seconds field clears the prescaler, so the next tick needs a full `TICKS_PER_SEC` units.
- R9: Seconds and minutes are 6 bits wide and hours are 5 bits wide. A written value at or beyond its limit keeps counting up to the top of the field, then wraps to 0 with no carry.
- R10: In a cycle with `wr_en` = 1 the written field takes the written value and no field advances from a tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_step | input | STEP_W | Counting units elapsed this cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Field chosen for the write |
| wr_data | input | 8 | Write value |
| rd_sel | input | 3 | Field chosen for the read |
| rd_data | output | 8 | Registered read value |

## Verification
Single-unit steps show exactly where the tick threshold lies. Three-unit steps that do not divide the threshold show whether the excess is kept or dropped. Full-second steps from preloaded boundary values (59/59/23 with day 0x0FF and with day 0x1FF) separate the cascade, the day-bit toggle and the overflow flag. Other tests make software writes interact with the prescaler: a partial sum held across a halt, and a seconds write that clears it. Further patterns cover out-of-range preloads and a write in the same cycle as a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam logic [2:0] SEL_SEC  = 3'd0;
  localparam logic [2:0] SEL_MIN  = 3'd1;
  localparam logic [2:0] SEL_HOUR = 3'd2;
  localparam logic [2:0] SEL_DAY  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [8:0] day;
    logic       halt;
    logic       ovf;
  } rtc_state_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned STEP_W        = 4,
  localparam int unsigned SUM_W        = $clog2(TICKS_PER_SEC + (1 << STEP_W)) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              clear,
  input  logic [STEP_W-1:0] step,
  output logic              tick,
  output logic [SUM_W-1:0]  acc_q
);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(TICKS_PER_SEC);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = acc_q + SUM_W'(step);
    tick = !hold && !clear && (sum >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (!hold) begin
      if (sum >= LIMIT) acc_q <= sum - LIMIT;
      else              acc_q <= sum;
    end
  end
endmodule

// File: rtl/rtc_cascade.sv
module rtc_cascade
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [7:0]       wr_data,
  output rtc_state_t       st_q
);
  rtc_state_t adv;
  logic c_min, c_hour, c_day;
  logic [5:0] sec_inc, min_inc;
  logic [4:0] hour_inc;
  logic [8:0] day_inc;

  always_comb begin
    adv      = st_q;
    sec_inc  = st_q.sec + 6'd1;
    min_inc  = st_q.min + 6'd1;
    hour_inc = st_q.hour + 5'd1;
    day_inc  = st_q.day + 9'd1;
    c_min    = (sec_inc == 6'd60);
    c_hour   = 1'b0;
    c_day    = 1'b0;
    adv.sec  = c_min ? 6'd0 : sec_inc;
    if (c_min) begin
      c_hour  = (min_inc == 6'd60);
      adv.min = c_hour ? 6'd0 : min_inc;
    end
    if (c_hour) begin
      c_day    = (hour_inc == 5'd24);
      adv.hour = c_day ? 5'd0 : hour_inc;
    end
    if (c_day) begin
      adv.day = day_inc;
      if (st_q.day == 9'h1FF) adv.ovf = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SEC:  st_q.sec     <= wr_data[5:0];
        SEL_MIN:  st_q.min     <= wr_data[5:0];
        SEL_HOUR: st_q.hour    <= wr_data[4:0];
        SEL_DAY:  st_q.day[7:0] <= wr_data;
        SEL_CTRL: begin
          st_q.ovf    <= wr_data[7];
          st_q.halt   <= wr_data[6];
          st_q.day[8] <= wr_data[0];
        end
        default: ;
      endcase
    end else if (tick && !st_q.halt) begin
      st_q <= adv;
    end
  end
endmodule

// File: rtl/cart_rtc.sv
module cart_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned STEP_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] unit_step,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        rd_sel,
  output logic [7:0]        rd_data
);
  localparam int unsigned SUM_W = $clog2(TICKS_PER_SEC + (1 << STEP_W)) + 1;

  rtc_state_t       st;
  logic             tick;
  logic [SUM_W-1:0] acc;
  logic             sec_wr;
  logic [7:0]       rd_mux;

  assign sec_wr = wr_en && (wr_sel == SEL_SEC);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .STEP_W(STEP_W)) u_pre (
    .clk(clk), .rst(rst), .hold(st.halt), .clear(sec_wr),
    .step(unit_step), .tick(tick), .acc_q(acc)
  );

  rtc_cascade u_casc (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .st_q(st)
  );

  always_comb begin
    case (rd_sel)
      SEL_SEC:  rd_mux = {2'b00, st.sec};
      SEL_MIN:  rd_mux = {2'b00, st.min};
      SEL_HOUR: rd_mux = {3'b000, st.hour};
      SEL_DAY:  rd_mux = st.day[7:0];
      SEL_CTRL: rd_mux = {st.ovf, st.halt, 5'b11111, st.day[8]};
      default:  rd_mux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/cart_rtc_chk.sv
module cart_rtc_chk #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned SUM_W         = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             tick,
  input logic             halt,
  input logic             ovf,
  input logic [5:0]       sec,
  input logic [8:0]       day,
  input logic [SUM_W-1:0] acc
);
  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !wr_en) |=> ($stable(sec) && $stable(day) && $stable(acc)));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !wr_en) |=> ovf);
  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    acc < SUM_W'(TICKS_PER_SEC));
  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !halt && !wr_en && sec == 6'd59) |=> (sec == 6'd0));
  // R10
  write_blocks_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tick) |=> (sec == $past(sec) || sec != $past(sec) + 6'd1));
endmodule

bind cart_rtc cart_rtc_chk #(.TICKS_PER_SEC(TICKS_PER_SEC), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .tick(tick), .halt(st.halt),
  .ovf(st.ovf), .sec(st.sec), .day(st.day), .acc(acc)
);

// File: tb/test_cart_rtc.sv
module test_cart_rtc;
  localparam int unsigned TPS = 10;
  localparam int unsigned SW  = 4;

  logic clk = 1'b0;
  logic rst;
  logic [SW-1:0] unit_step;
  logic wr_en;
  logic [2:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cart_rtc #(.TICKS_PER_SEC(TPS), .STEP_W(SW)) i_cart_rtc (
    .clk(clk), .rst(rst), .unit_step(unit_step), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [2:0] sel, input logic [7:0] exp);
    @(negedge clk); rd_sel = sel;
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d, input logic [SW-1:0] st = '0);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d; unit_step = st;
    @(negedge clk); wr_en = 1'b0; unit_step = '0;
  endtask

  task automatic units(input logic [SW-1:0] st, input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); unit_step = st;
    end
    @(negedge clk); unit_step = '0;
  endtask

  task automatic preload(input logic [7:0] s, m, h, dl, c);
    wr(3'd1, m); wr(3'd2, h); wr(3'd3, dl); wr(3'd4, c); wr(3'd0, s);
  endtask

  task automatic t_reset;
    check("R1 sec", 3'd0, 8'h00); check("R1 min", 3'd1, 8'h00);
    check("R1 hour", 3'd2, 8'h00); check("R1 day", 3'd3, 8'h00);
    check("R1 ctrl", 3'd4, 8'h3E); check("R1 unused", 3'd6, 8'hFF);
  endtask

  task automatic t_latency;
    wr(3'd1, 8'd17);
    @(negedge clk); rd_sel = 3'd1;
    @(posedge clk); #1;
    n_chk++;
    if (rd_data !== 8'd17) begin
      n_bad++; $display("FAIL R2 actual=%h expected=%h", rd_data, 8'd17);
    end
  endtask

  task automatic t_prescale;
    wr(3'd0, 8'd0);
    units(4'd1, 9);  check("R3 below threshold", 3'd0, 8'd0);
    units(4'd1, 1);  check("R3 at threshold", 3'd0, 8'd1);
    units(4'd3, 4);  check("R3 remainder tick", 3'd0, 8'd2);
    units(4'd3, 2);  check("R3 remainder kept", 3'd0, 8'd2);
    units(4'd3, 1);  check("R3 remainder second", 3'd0, 8'd3);
  endtask

  task automatic t_cascade;
    preload(8'd59, 8'd59, 8'd23, 8'hFF, 8'h00);
    units(4'd10, 1);
    check("R4 sec", 3'd0, 8'd0); check("R4 min", 3'd1, 8'd0);
    check("R4 hour", 3'd2, 8'd0); check("R5 day low", 3'd3, 8'h00);
    check("R5 day bit8", 3'd4, 8'h3F);
  endtask

  task automatic t_overflow;
    preload(8'd59, 8'd59, 8'd23, 8'hFF, 8'h01);
    units(4'd10, 1);
    check("R6 ovf set", 3'd4, 8'hBE); check("R5 wrap low", 3'd3, 8'h00);
    units(4'd10, 1);
    check("R6 ovf sticky", 3'd4, 8'hBE);
    wr(3'd4, 8'h00);
    check("R6 ovf cleared", 3'd4, 8'h3E);
  endtask

  task automatic t_halt;
    wr(3'd0, 8'd5);
    units(4'd7, 1);
    wr(3'd4, 8'h40);
    check("R7 halt reads", 3'd4, 8'h7E);
    units(4'd15, 3);
    check("R7 frozen", 3'd0, 8'd5);
    wr(3'd4, 8'h00);
    units(4'd2, 1); check("R7 prescaler held", 3'd0, 8'd5);
    units(4'd1, 1); check("R7 resumed", 3'd0, 8'd6);
  endtask

  task automatic t_sec_clear;
    wr(3'd0, 8'd0);
    units(4'd8, 1);
    wr(3'd0, 8'd20);
    units(4'd8, 1); check("R8 cleared", 3'd0, 8'd20);
    units(4'd2, 1); check("R8 full second", 3'd0, 8'd21);
  endtask

  task automatic t_range;
    preload(8'd62, 8'd4, 8'd0, 8'd0, 8'h00);
    units(4'd10, 1); check("R9 sec 63", 3'd0, 8'd63);
    units(4'd10, 1); check("R9 sec wraps", 3'd0, 8'd0);
    check("R9 no carry", 3'd1, 8'd4);
    preload(8'd59, 8'd59, 8'd30, 8'd9, 8'h00);
    units(4'd10, 1); check("R9 hour 31", 3'd2, 8'd31);
    preload(8'd59, 8'd59, 8'd31, 8'd9, 8'h00);
    units(4'd10, 1); check("R9 hour wrap", 3'd2, 8'd0);
    check("R9 day untouched", 3'd3, 8'd9);
  endtask

  task automatic t_write_tick;
    wr(3'd0, 8'd30);
    units(4'd9, 1);
    wr(3'd1, 8'd12, 4'd1);
    check("R10 sec held", 3'd0, 8'd30);
    check("R10 min written", 3'd1, 8'd12);
  endtask

  initial begin
    rst = 1'b1; unit_step = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset; t_latency; t_prescale; t_cascade; t_overflow;
    t_halt; t_sec_clear; t_range; t_write_tick;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule